// File: doc/BRIEF.md
# Relocatable RAM Window Decoder

This block decodes a 16-bit bus address space for a 2 KB internal RAM that can be moved to any 2 KB boundary. A mapping register holds a five-bit window position, which gives the upper five address bits of the RAM, and a control bit that turns the RAM decode off while the device is in wait mode. The mapping register sits at offset 0x010 of a movable 512-byte register block. That block always wins over the RAM window where the two overlap.

The RAM select and the RAM-local address are combinational, so they are valid in the same cycle as the bus address. Writes to the mapping register take effect at the next rising clock edge. The rules for accepting a write depend on the operating mode. In normal mode the window position can be written only once after reset, while the wait-shutdown bit can be written at any time. In special mode the position can be rewritten freely, and the wait-shutdown bit cannot be written at all.

Top module: `ram_window_decoder`

## Requirements
- R1: After reset the window position is 0 and the wait-shutdown bit is 0, so the mapping register reads 0x00 and the window covers 0x0000..0x07FF.
- R2: `ramSel` is 1 exactly when all three of these hold:
  - `busAddr[15:11]` equals the window position;
  - the address is outside the register block;
  - the decode is not shut down.
- R2 (continued): `ramAddr` equals `busAddr[10:0]` in every cycle.
- R3: The mapping register is at the address where `busAddr[15:9]` equals `regBase` and `busAddr[8:0]` equals 0x010. Its layout is:
  - window position in bits 7:3;
  - wait-shutdown bit in bit 0;
  - bits 2:1 always read 0.
- R3 (continued): `rdData` shows the register in the same cycle when `rdEn` is high at that address, and is 0x00 otherwise.
- R4: In normal mode only the first accepted normal-mode position write after reset changes the position. The new value is visible from the next cycle. Later normal-mode writes leave the position unchanged.
- R5: In special mode every write to the mapping register loads the position. Special-mode writes do not use up the single normal-mode write.
- R6: An address inside the register block (`busAddr[15:9] == regBase`) never selects RAM, even when it also falls inside the window.
- R7: When the wait-shutdown bit is 1 and `inWait` is 1, `ramSel` is 0. When the bit is 0, decoding continues during wait.
- R8: Every normal-mode write to the mapping register loads the wait-shutdown bit from `wrData[0]`, even after the position is locked. Special-mode writes never change it.
- R9: Writes to any other address, including other offsets of the register block, change neither field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 16 | Bus address |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| specialMode | input | 1 | 1 = special mode, 0 = normal mode |
| inWait | input | 1 | Device is in wait mode |
| regBase | input | 7 | Register block base, address bits 15:9 |
| ramSel | output | 1 | RAM window select |
| ramAddr | output | 11 | RAM-local address |
| rdData | output | 8 | Mapping register read data |

## Verification
The assertions check on every cycle the rules that hold whatever the stimulus:
- a register-block hit never coexists with a RAM select;
- an active wait shutdown keeps RAM deselected;
- once locked in normal mode, the position is not loaded again;
- the wait-shutdown bit is never loaded in special mode.

Only the bench scenarios can show the order-dependent behaviour:
- the first normal write sticks while later ones are ignored;
- special-mode writes, even when made first, leave the normal write-once intact;
- reserved bits read as zero;
- moving the register block changes which RAM bytes are hidden.

// File: rtl/ram_window_pkg.sv
package ram_window_pkg;
  // Strobes from the control path to the datapath
  typedef struct packed {
    logic posWr;   // load the window position field
    logic waitWr;  // load the wait-shutdown bit
    logic mapRd;   // drive the mapping register onto rdData
    logic regHit;  // current address falls in the register block
  } map_strobe_t;
endpackage

// File: rtl/ram_window_ctrl.sv
module ram_window_ctrl
  import ram_window_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int REG_AW     = 9,
  parameter int MAP_OFFSET = 'h010
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     rdEn,
  input  logic                     wrEn,
  input  logic                     specialMode,
  input  logic [ADDR_W-REG_AW-1:0] regBase,
  output map_strobe_t              strb
);
  localparam logic [REG_AW-1:0] MapOff = REG_AW'(MAP_OFFSET);

  logic regHit, mapHit, mapWr, lockQ;

  assign regHit = (busAddr[ADDR_W-1:REG_AW] == regBase);
  assign mapHit = regHit && (busAddr[REG_AW-1:0] == MapOff);
  assign mapWr  = mapHit && wrEn;

  always_comb begin
    strb.regHit = regHit;
    strb.mapRd  = mapHit && rdEn;
    strb.posWr  = mapWr && (specialMode || !lockQ);
    strb.waitWr = mapWr && !specialMode;
  end

  // Write-once lock: set by the first accepted normal-mode position write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            lockQ <= 1'b0;
    else if (strb.posWr && !specialMode)  lockQ <= 1'b1;
  end

  assert_lock_R4: assert property (@(posedge clk) disable iff (!rstN)
    (lockQ && !specialMode) |-> !strb.posWr);
  assert_no_wait_wr_special_R8: assert property (@(posedge clk) disable iff (!rstN)
    specialMode |-> !strb.waitWr);
endmodule

// File: rtl/ram_window_dp.sv
module ram_window_dp
  import ram_window_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int RAM_AW   = 11,
  parameter int DATA_W   = 8,
  parameter int POS_LSB  = 3,
  parameter int WAIT_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              inWait,
  input  map_strobe_t       strb,
  output logic              ramSel,
  output logic [RAM_AW-1:0] ramAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int POS_W = ADDR_W - RAM_AW;
  localparam logic [DATA_W-1:0] PosMask  = DATA_W'(((1 << POS_W) - 1) << POS_LSB);
  localparam logic [DATA_W-1:0] WaitMask = DATA_W'(1 << WAIT_BIT);

  generate
    if (POS_LSB + POS_W > DATA_W || (WAIT_BIT >= POS_LSB && WAIT_BIT < POS_LSB + POS_W))
      $error("mapping register fields do not fit");
  endgenerate

  logic [DATA_W-1:0] mapQ, loadMask;
  logic [POS_W-1:0]  posQ;
  logic              waitOffQ, shutDown;

  assign loadMask = (strb.posWr ? PosMask : '0) | (strb.waitWr ? WaitMask : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mapQ <= '0;
    else       mapQ <= (mapQ & ~loadMask) | (wrData & loadMask);
  end

  assign posQ     = mapQ[POS_LSB +: POS_W];
  assign waitOffQ = mapQ[WAIT_BIT];
  assign shutDown = inWait && waitOffQ;

  assign ramSel  = (busAddr[ADDR_W-1:RAM_AW] == posQ) && !strb.regHit && !shutDown;
  assign ramAddr = busAddr[RAM_AW-1:0];
  assign rdData  = strb.mapRd ? mapQ : '0;

  assert_reg_priority_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.regHit |-> !ramSel);
  assert_wait_shutdown_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inWait && mapQ[WAIT_BIT]) |-> !ramSel);
  assert_pos_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.posWr |=> $stable(posQ));
  assert_wait_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.waitWr |=> $stable(waitOffQ));
endmodule

// File: rtl/ram_window_decoder.sv
module ram_window_decoder
  import ram_window_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int RAM_AW     = 11,
  parameter int REG_AW     = 9,
  parameter int DATA_W     = 8,
  parameter int MAP_OFFSET = 'h010,
  parameter int POS_LSB    = 3,
  parameter int WAIT_BIT   = 0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     rdEn,
  input  logic                     wrEn,
  input  logic [DATA_W-1:0]        wrData,
  input  logic                     specialMode,
  input  logic                     inWait,
  input  logic [ADDR_W-REG_AW-1:0] regBase,
  output logic                     ramSel,
  output logic [RAM_AW-1:0]        ramAddr,
  output logic [DATA_W-1:0]        rdData
);
  map_strobe_t strb;

  ram_window_ctrl #(
    .ADDR_W(ADDR_W), .REG_AW(REG_AW), .MAP_OFFSET(MAP_OFFSET)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .rdEn(rdEn), .wrEn(wrEn),
    .specialMode(specialMode), .regBase(regBase), .strb(strb)
  );

  ram_window_dp #(
    .ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .DATA_W(DATA_W),
    .POS_LSB(POS_LSB), .WAIT_BIT(WAIT_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .wrData(wrData), .inWait(inWait),
    .strb(strb), .ramSel(ramSel), .ramAddr(ramAddr), .rdData(rdData)
  );
endmodule

// File: tb/ram_window_decoder_tb.sv
`timescale 1ns/1ps
module ram_window_decoder_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        rdEn = 1'b0, wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic        specialMode = 1'b0, inWait = 1'b0;
  logic [6:0]  regBase = '0;
  logic        ramSel;
  logic [10:0] ramAddr;
  logic [7:0]  rdData;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct {
    logic        sel;
    logic [10:0] addr;
    logic [7:0]  data;
    string       tag;
  } exp_t;
  exp_t q[$];
  event sampleEv;

  // Requirement model
  bit [4:0] mPos;
  bit mWait, mLock;

  always #2 clk = ~clk;

  ram_window_decoder u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .specialMode(specialMode), .inWait(inWait), .regBase(regBase),
    .ramSel(ramSel), .ramAddr(ramAddr), .rdData(rdData)
  );

  task automatic doReset();
    rstN = 1'b0; mPos = '0; mWait = 1'b0; mLock = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic step(input logic [15:0] a, input bit rd, input bit wr,
                      input logic [7:0] d, input string tag);
    exp_t e;
    bit inBlk, isMap;
    @(negedge clk);
    busAddr = a; rdEn = rd; wrEn = wr; wrData = d;
    inBlk = (a[15:9] == regBase);
    isMap = inBlk && (a[8:0] == 9'h010);
    e.sel  = (a[15:11] == mPos) && !inBlk && !(inWait && mWait);
    e.addr = a[10:0];
    e.data = (rd && isMap) ? {mPos, 2'b00, mWait} : 8'h00;
    e.tag  = tag;
    q.push_back(e);
    #1 -> sampleEv;
    @(posedge clk);
    #1 rdEn = 1'b0; wrEn = 1'b0;
    if (wr && isMap) begin
      if (specialMode || !mLock) begin
        mPos = d[7:3];
        if (!specialMode) mLock = 1'b1;
      end
      if (!specialMode) mWait = d[0];
    end
  endtask

  // Monitor: pop and compare
  initial begin
    forever begin
      @(sampleEv);
      #0;
      if (q.size() != 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (ramSel !== e.sel || ramAddr !== e.addr || rdData !== e.data) begin
          failures++;
          $display("FAIL %s: actual sel=%0b addr=%h data=%h expected sel=%0b addr=%h data=%h",
                   e.tag, ramSel, ramAddr, rdData, e.sel, e.addr, e.data);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1: reset state, register block at 0x0000 hides RAM bytes 0..511
    step(16'h0010, 1, 0, 8'h00, "R1 map reads zero after reset");
    step(16'h0010, 0, 0, 8'h00, "R6 reg block hides RAM after reset");
    step(16'h0200, 0, 0, 8'h00, "R1 RAM at 0x0200 after reset");
    step(16'h07FF, 1, 0, 8'h00, "R2 top of window, no read data");
    step(16'h0800, 0, 0, 8'h00, "R2 outside window");
    // Move register block to 0x0800
    regBase = 7'd4;
    step(16'h0010, 0, 0, 8'h00, "R6 RAM uncovered after block moves");
    step(16'h0810, 0, 1, 8'h18, "R4 first normal write pos=3");
    step(16'h0810, 1, 0, 8'h00, "R3 read back pos=3");
    step(16'h1800, 0, 0, 8'h00, "R2 new window base");
    step(16'h17FF, 0, 0, 8'h00, "R2 below new window");
    step(16'h1FFF, 0, 0, 8'h00, "R2 window top local addr");
    step(16'h0810, 0, 1, 8'h2F, "R4 second normal write ignored for pos");
    step(16'h0810, 1, 0, 8'h00, "R8 wait bit loaded, pos kept, reserved zero");
    step(16'h0810, 1, 1, 8'h2E, "R3 read during write shows old value");
    step(16'h0810, 1, 0, 8'h00, "R8 wait bit cleared after lock");
    step(16'h0810, 0, 1, 8'h01, "R8 set wait bit");
    inWait = 1'b1;
    step(16'h1800, 0, 0, 8'h00, "R7 shutdown in wait");
    step(16'h0810, 1, 0, 8'h00, "R7 register still readable in wait");
    step(16'h0810, 0, 1, 8'h00, "R8 clear wait bit in wait");
    step(16'h1800, 0, 0, 8'h00, "R7 decode continues in wait when bit 0");
    inWait = 1'b0;
    // R9: other addresses
    step(16'h0811, 0, 1, 8'hF9, "R9 other offset write");
    step(16'h0810, 1, 0, 8'h00, "R9 no change after offset write");
    step(16'h1810, 0, 1, 8'hF9, "R9 write outside block");
    step(16'h0810, 1, 0, 8'h00, "R9 no change after outside write");
    // R5 special mode
    specialMode = 1'b1;
    step(16'h0810, 0, 1, 8'h49, "R5 special write pos=9");
    step(16'h0810, 1, 0, 8'h00, "R5 pos=9, R8 wait bit untouched");
    step(16'h0810, 0, 1, 8'h08, "R5 special write pos=1");
    step(16'h0900, 0, 0, 8'h00, "R6 overlap: block wins");
    step(16'h0A00, 0, 0, 8'h00, "R6 overlap: RAM above block");
    step(16'h0810, 1, 0, 8'h00, "R5 read pos=1");
    // R5: special writes do not consume the normal write-once
    specialMode = 1'b0;
    doReset();
    regBase = 7'd4;
    specialMode = 1'b1;
    step(16'h0810, 0, 1, 8'h30, "R5 special write before normal");
    specialMode = 1'b0;
    step(16'h0810, 0, 1, 8'h50, "R5 normal write still accepted");
    step(16'h0810, 1, 0, 8'h00, "R5 pos=10 after normal write");
    step(16'h0810, 0, 1, 8'h60, "R4 later normal write ignored");
    step(16'h5000, 1, 0, 8'h00, "R4 window still at pos 10");
    repeat (3) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule